// File: doc/BRIEF.md
# Video Memory Block Copy Engine

This block copies data from a source memory into the video memory window in fixed 16-byte blocks. Software programs a source address, a destination address and a block count through five byte-wide registers. A write to the control register starts a transfer in one of two modes.

In burst mode, every block is copied back to back while the processor is held stalled. In line mode, one block is copied at each horizontal blank of a visible line, and the processor runs freely between blocks. A line-mode transfer can be cancelled between blocks. The control register always reports how many blocks are left and whether a transfer is still running.

The source side is a synchronous read port: data appears one clock after the read strobe. The video memory side is a plain write strobe that accepts one byte in every cycle in which it is driven. That port has no back-pressure, so the memory it drives must take each byte in the cycle in which it is presented.

Top module: `vram_block_dma`

## Requirements
- R1: Register 0 holds source address bits 15:8. Register 1 holds source bits 7:4, taken from write-data bits 7:4. Source bits 3:0 are always zero, so register 1 reads back with its low nibble clear.
- R2: Register 2 holds destination bits 12:8, taken from write-data bits 4:0. Register 3 holds destination bits 7:4, taken from write-data bits 7:4. Destination bit 15 is always 1 and bits 14:13 and 3:0 are always 0. Register 2 reads back as {3'b100, bits 12:8}, and every video write address lies in 0x8000–0x9FFF.
- R3: Register 4 is the control register. A write loads bits 6:0 as the block count minus one, and bit 7 selects the mode: 1 is line mode, 0 is burst mode. A read returns {idle, remaining}, where idle is 1 when no transfer is active. The register reads 0xFF after reset, and register numbers 5 to 7 read 0xFF.
- R4: In burst mode, all blocks are copied without processor interaction. cpu_stall rises in the cycle after the control write and stays high until the cycle in which the last byte is written. The transfer is inactive after that.
- R5: In line mode, a block starts only in a cycle in which hblank rises while line_visible is high. A long hblank starts at most one block, no block starts while line_visible is low, and a transfer started while hblank is already high waits for the next rise.
- R6: A block is 16 reads in consecutive cycles at source+0 to source+15. Each read is followed one cycle later by a write of the returned byte to the matching destination offset.
- R7: After each block, the source and the destination each advance by 16, and the destination wraps from 0x9FF0 to 0x8000. The remaining count decrements, and a block that finishes with count 0 leaves the count at 0x7F and ends the transfer.
- R8: During an active line-mode transfer, a control write with bit 7 clear cancels the transfer and keeps the remaining count, so the register reads 0x80 | remaining. A control write with bit 7 set is ignored.
- R9: Every register write made while cpu_stall is high is ignored.
- R10: In line mode, cpu_stall is high for exactly the 17 cycles of a moving block and low between blocks. A video write never occurs while cpu_stall is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register number for both write and read |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Combinational readback of the register selected by reg_addr |
| src_rd_en | output | 1 | Source read strobe |
| src_rd_addr | output | 16 | Source read address |
| src_rd_data | input | 8 | Source data, valid the cycle after src_rd_en |
| vram_wr_en | output | 1 | Video memory write strobe |
| vram_wr_addr | output | 16 | Video memory write address |
| vram_wr_data | output | 8 | Video memory write data |
| hblank | input | 1 | Horizontal blank level |
| line_visible | input | 1 | High while the current line is one of the visible lines |
| cpu_stall | output | 1 | Processor hold request |

## Verification
The bench holds the hblank level for tens of cycles. A design that triggered on the level instead of the rise would copy several blocks in one blank. The bench also raises hblank with line_visible low and checks that nothing moves. It starts a line transfer while hblank is already high, which catches a design that takes the first blank without waiting for a rise.

Other stimuli target the count and address boundaries. A destination placed at 0x9FF0 shows whether the address wraps back into the window or escapes it. Reading the control register after the last block shows whether the count wraps to 0x7F and the active flag clears. After a cancel, the readback exposes a design that clears the count or ignores the cancel.

A register write issued in the middle of a burst catches a design that lets the source address be corrupted while data is moving. A control write with bit 7 set during a line transfer catches a design that restarts the transfer instead of ignoring the write.

// File: rtl/vdma_pkg.sv
package vdma_pkg;
  localparam int BLK_LOG2 = 4;
  localparam int ADDR_W   = 16;
  localparam int SRC_W    = ADDR_W - BLK_LOG2;
  localparam int DST_W    = 13 - BLK_LOG2;
  localparam int CNT_W    = 7;

  localparam logic [2:0] RA_SRC_HI = 3'd0;
  localparam logic [2:0] RA_SRC_LO = 3'd1;
  localparam logic [2:0] RA_DST_HI = 3'd2;
  localparam logic [2:0] RA_DST_LO = 3'd3;
  localparam logic [2:0] RA_CTRL   = 3'd4;

  typedef enum logic {XFER_BURST = 1'b0, XFER_LINE = 1'b1} xfer_mode_e;
endpackage

// File: rtl/vdma_rise.sv
module vdma_rise (
  input  logic clk,
  input  logic rst_n,
  input  logic level,
  output logic rise
);
  logic prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= 1'b0;
    else        prev_q <= level;
  end

  assign rise = level & ~prev_q;
endmodule

// File: rtl/vdma_regs.sv
module vdma_regs
  import vdma_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [2:0]       addr,
  input  logic [7:0]       wr_data,
  output logic [7:0]       rd_data,
  input  logic             lock,
  input  logic             block_done,
  output logic [SRC_W-1:0] src_blk,
  output logic [DST_W-1:0] dst_blk,
  output logic             active,
  output xfer_mode_e       mode,
  output logic [CNT_W-1:0] remain
);
  localparam int LO_W = 8 - BLK_LOG2;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      src_blk <= '0;
      dst_blk <= '0;
      active  <= 1'b0;
      mode    <= XFER_BURST;
      remain  <= '1;
    end else begin
      if (block_done) begin
        src_blk <= src_blk + 1'b1;
        dst_blk <= dst_blk + 1'b1;
        remain  <= remain - 1'b1;
        if (remain == '0) active <= 1'b0;
      end
      if (wr_en && !lock) begin
        case (addr)
          RA_SRC_HI: src_blk[SRC_W-1:LO_W] <= wr_data;
          RA_SRC_LO: src_blk[LO_W-1:0]     <= wr_data[7:BLK_LOG2];
          RA_DST_HI: dst_blk[DST_W-1:LO_W] <= wr_data[DST_W-LO_W-1:0];
          RA_DST_LO: dst_blk[LO_W-1:0]     <= wr_data[7:BLK_LOG2];
          RA_CTRL: begin
            if (active && mode == XFER_LINE) begin
              if (!wr_data[7]) active <= 1'b0;
            end else begin
              remain <= wr_data[CNT_W-1:0];
              mode   <= xfer_mode_e'(wr_data[7]);
              active <= 1'b1;
            end
          end
          default: ;
        endcase
      end
    end
  end

  always_comb begin
    case (addr)
      RA_SRC_HI: rd_data = src_blk[SRC_W-1:LO_W];
      RA_SRC_LO: rd_data = {src_blk[LO_W-1:0], {BLK_LOG2{1'b0}}};
      RA_DST_HI: rd_data = {3'b100, dst_blk[DST_W-1:LO_W]};
      RA_DST_LO: rd_data = {dst_blk[LO_W-1:0], {BLK_LOG2{1'b0}}};
      RA_CTRL:   rd_data = {~active, remain};
      default:   rd_data = 8'hFF;
    endcase
  end

  // R7
  remain_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (block_done && remain == '0) |=> (!active && remain == '1));

  // R9
  locked_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (lock && wr_en && !block_done) |=> ($stable(src_blk) && $stable(dst_blk) && $stable(mode)));
endmodule

// File: rtl/vdma_mover.sv
module vdma_mover
  import vdma_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [SRC_W-1:0]  src_blk,
  input  logic [DST_W-1:0]  dst_blk,
  output logic              busy,
  output logic              block_done,
  output logic              rd_en,
  output logic [ADDR_W-1:0] rd_addr,
  output logic              wr_en,
  output logic [ADDR_W-1:0] wr_addr
);
  logic [BLK_LOG2:0] step;
  logic              last;

  assign last       = step[BLK_LOG2];
  assign rd_en      = busy & ~last;
  assign rd_addr    = {src_blk, step[BLK_LOG2-1:0]};
  assign block_done = busy & last;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy    <= 1'b0;
      step    <= '0;
      wr_en   <= 1'b0;
      wr_addr <= '0;
    end else begin
      wr_en   <= rd_en;
      wr_addr <= {3'b100, dst_blk, step[BLK_LOG2-1:0]};
      if (!busy) begin
        if (start) begin
          busy <= 1'b1;
          step <= '0;
        end
      end else if (last) begin
        busy <= 1'b0;
      end else begin
        step <= step + 1'b1;
      end
    end
  end

  // R6
  wr_follows_rd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en |=> (wr_en && wr_addr[BLK_LOG2-1:0] == $past(rd_addr[BLK_LOG2-1:0])));

  // R10
  done_ends_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    block_done |=> !busy);
endmodule

// File: rtl/vram_block_dma.sv
module vram_block_dma
  import vdma_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        reg_wr,
  input  logic [2:0]  reg_addr,
  input  logic [7:0]  reg_wdata,
  output logic [7:0]  reg_rdata,
  output logic        src_rd_en,
  output logic [15:0] src_rd_addr,
  input  logic [7:0]  src_rd_data,
  output logic        vram_wr_en,
  output logic [15:0] vram_wr_addr,
  output logic [7:0]  vram_wr_data,
  input  logic        hblank,
  input  logic        line_visible,
  output logic        cpu_stall
);
  logic [SRC_W-1:0] src_blk;
  logic [DST_W-1:0] dst_blk;
  logic             active, busy, block_done, hb_rise, ctrl_wr, start;
  logic [CNT_W-1:0] remain;
  xfer_mode_e       mode;

  assign ctrl_wr   = reg_wr && reg_addr == RA_CTRL;
  assign cpu_stall = busy | (active & (mode == XFER_BURST));
  assign start     = active & ~busy &
                     ((mode == XFER_BURST) | (hb_rise & line_visible & ~ctrl_wr));
  assign vram_wr_data = src_rd_data;

  vdma_rise u_rise (
    .clk   (clk),
    .rst_n (rst_n),
    .level (hblank),
    .rise  (hb_rise)
  );

  vdma_regs u_regs (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_en      (reg_wr),
    .addr       (reg_addr),
    .wr_data    (reg_wdata),
    .rd_data    (reg_rdata),
    .lock       (cpu_stall),
    .block_done (block_done),
    .src_blk    (src_blk),
    .dst_blk    (dst_blk),
    .active     (active),
    .mode       (mode),
    .remain     (remain)
  );

  vdma_mover u_mover (
    .clk        (clk),
    .rst_n      (rst_n),
    .start      (start),
    .src_blk    (src_blk),
    .dst_blk    (dst_blk),
    .busy       (busy),
    .block_done (block_done),
    .rd_en      (src_rd_en),
    .rd_addr    (src_rd_addr),
    .wr_en      (vram_wr_en),
    .wr_addr    (vram_wr_addr)
  );

  // R10
  stall_covers_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    vram_wr_en |-> cpu_stall);

  // R2
  dst_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
    vram_wr_en |-> (vram_wr_addr[15:13] == 3'b100));

  // R5
  line_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(busy) && mode == XFER_LINE) |-> $past(hb_rise && line_visible));
endmodule

// File: tb/vram_block_dma_bench.sv
module vram_block_dma_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr = 1'b0;
  logic [2:0]  reg_addr = 3'd4;
  logic [7:0]  reg_wdata = 8'h00;
  logic [7:0]  reg_rdata;
  logic        src_rd_en;
  logic [15:0] src_rd_addr;
  logic [7:0]  src_rd_data = 8'h00;
  logic        vram_wr_en;
  logic [15:0] vram_wr_addr;
  logic [7:0]  vram_wr_data;
  logic        hblank = 1'b0;
  logic        line_visible = 1'b0;
  logic        cpu_stall;

  int checks = 0;
  int failures = 0;
  int wr_seen = 0;
  bit done_flag = 0;

  always #5 clk = ~clk;

  vram_block_dma u_vram_block_dma (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .src_rd_en(src_rd_en),
    .src_rd_addr(src_rd_addr), .src_rd_data(src_rd_data),
    .vram_wr_en(vram_wr_en), .vram_wr_addr(vram_wr_addr),
    .vram_wr_data(vram_wr_data), .hblank(hblank),
    .line_visible(line_visible), .cpu_stall(cpu_stall)
  );

  function automatic logic [7:0] mfun(input logic [15:0] a);
    return a[7:0] ^ {a[11:8], a[15:12]} ^ 8'h5A;
  endfunction

  always @(posedge clk) if (src_rd_en) src_rd_data <= mfun(src_rd_addr);

  // Behavioural reference model
  int m_busy, m_step, m_active, m_hb, m_remain, m_src, m_dst, m_prev;
  int t_stall, t_rise, t_wctrl;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_busy = 0; m_step = 0; m_active = 0; m_hb = 0;
      m_remain = 127; m_src = 0; m_dst = 0; m_prev = 0;
    end else begin
      t_stall = (m_busy != 0 || (m_active != 0 && m_hb == 0)) ? 1 : 0;
      t_rise  = (hblank && m_prev == 0) ? 1 : 0;
      t_wctrl = (reg_wr && reg_addr == 3'd4) ? 1 : 0;
      m_prev  = hblank ? 1 : 0;
      if (m_busy != 0) begin
        if (m_step == 16) begin
          m_busy = 0;
          m_src = (m_src + 1) % 4096;
          m_dst = (m_dst + 1) % 512;
          if (m_remain == 0) begin m_remain = 127; m_active = 0; end
          else m_remain = m_remain - 1;
        end else m_step = m_step + 1;
      end else if (m_active != 0 && m_hb == 0) begin
        m_busy = 1; m_step = 0;
      end else if (m_active != 0 && t_rise != 0 && line_visible && t_wctrl == 0) begin
        m_busy = 1; m_step = 0;
      end
      if (reg_wr && t_stall == 0) begin
        case (reg_addr)
          3'd0: m_src = (m_src % 16) + 16 * reg_wdata;
          3'd1: m_src = (m_src / 16) * 16 + reg_wdata / 16;
          3'd2: m_dst = (m_dst % 16) + 16 * (reg_wdata % 32);
          3'd3: m_dst = (m_dst / 16) * 16 + reg_wdata / 16;
          3'd4: begin
            if (m_active != 0 && m_hb != 0) begin
              if (reg_wdata[7] == 1'b0) m_active = 0;
            end else begin
              m_remain = reg_wdata % 128; m_hb = reg_wdata[7]; m_active = 1;
            end
          end
          default: ;
        endcase
      end
    end
  end

  function automatic int exp_rd(input logic [2:0] a);
    case (a)
      3'd0: return m_src / 16;
      3'd1: return (m_src % 16) * 16;
      3'd2: return 128 + m_dst / 16;
      3'd3: return (m_dst % 16) * 16;
      3'd4: return (m_active != 0 ? 0 : 128) + m_remain;
      default: return 255;
    endcase
  endfunction

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  // Per-clock comparison against the model
  always @(negedge clk) begin
    if (rst_n && !done_flag) begin
      chk("R4/R10 cpu_stall", cpu_stall,
          (m_busy != 0 || (m_active != 0 && m_hb == 0)) ? 1 : 0);
      chk("R6 vram_wr_en", vram_wr_en, (m_busy != 0 && m_step >= 1) ? 1 : 0);
      if (m_busy != 0 && m_step >= 1) begin
        chk("R2/R7 vram_wr_addr", vram_wr_addr, 32768 + m_dst * 16 + m_step - 1);
        chk("R6 vram_wr_data", vram_wr_data, mfun(16'(m_src * 16 + m_step - 1)));
      end
      chk("R3 reg_rdata", reg_rdata, exp_rd(reg_addr));
      if (vram_wr_en) wr_seen++;
    end
  end

  task automatic wr_reg(input logic [2:0] a, input logic [7:0] d);
    @(posedge clk); #2;
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(posedge clk); #2;
    reg_wr = 1'b0;
  endtask

  task automatic rd_chk(input string tag, input logic [2:0] a, input int exp);
    @(posedge clk); #2;
    reg_addr = a;
    @(negedge clk);
    chk(tag, reg_rdata, exp);
  endtask

  task automatic hb_pulse(input int len, input bit vis);
    @(posedge clk); #2;
    hblank = 1'b1; line_visible = vis;
    repeat (len) @(posedge clk);
    #2 hblank = 1'b0;
    repeat (10) @(posedge clk);
  endtask

  task automatic wait_idle();
    for (int i = 0; i < 3000; i++) begin
      @(negedge clk);
      if (!cpu_stall) break;
    end
  endtask

  int w0;

  initial begin
    repeat (4) @(posedge clk);
    #2 rst_n = 1'b1;
    @(negedge clk);
    chk("R3 reset ctrl reads FF", reg_rdata, 8'hFF);
    chk("R10 reset stall low", cpu_stall, 0);

    wr_reg(3'd0, 8'h12);
    wr_reg(3'd1, 8'h3F);
    rd_chk("R1 src low nibble cleared", 3'd1, 8'h30);
    wr_reg(3'd2, 8'hFF);
    wr_reg(3'd3, 8'hAB);
    rd_chk("R2 dst high masked", 3'd2, 8'h9F);
    rd_chk("R2 dst low masked", 3'd3, 8'hA0);
    rd_chk("R3 unused register", 3'd7, 8'hFF);

    // R4 burst of three blocks, R9 write while stalled
    w0 = wr_seen;
    wr_reg(3'd4, 8'h02);
    repeat (3) @(posedge clk);
    wr_reg(3'd0, 8'hEE);
    wait_idle();
    repeat (2) @(posedge clk);
    chk("R4 burst byte count", wr_seen - w0, 48);
    rd_chk("R7 ctrl after burst", 3'd4, 8'hFF);
    rd_chk("R9 src high unchanged", 3'd0, 8'h12);
    rd_chk("R7 src advanced", 3'd1, 8'h60);
    rd_chk("R7 dst advanced", 3'd3, 8'hD0);

    // R7 destination wrap
    wr_reg(3'd3, 8'hF0);
    w0 = wr_seen;
    wr_reg(3'd4, 8'h01);
    wait_idle();
    repeat (2) @(posedge clk);
    chk("R7 wrap burst byte count", wr_seen - w0, 32);
    rd_chk("R7 dst wrapped high", 3'd2, 8'h80);
    rd_chk("R7 dst wrapped low", 3'd3, 8'h10);

    // R5/R8/R10 line mode
    wr_reg(3'd4, 8'h83);
    rd_chk("R3 line mode active", 3'd4, 8'h03);
    chk("R10 no stall between blocks", cpu_stall, 0);
    w0 = wr_seen;
    hb_pulse(60, 1'b1);
    chk("R5 one block per long blank", wr_seen - w0, 16);
    rd_chk("R7 count after block", 3'd4, 8'h02);
    w0 = wr_seen;
    hb_pulse(30, 1'b0);
    chk("R5 no block off visible lines", wr_seen - w0, 0);
    wr_reg(3'd4, 8'h85);
    rd_chk("R8 set-bit write ignored", 3'd4, 8'h02);
    hb_pulse(30, 1'b1);
    wr_reg(3'd4, 8'h00);
    rd_chk("R8 cancel keeps count", 3'd4, 8'h81);
    w0 = wr_seen;
    hb_pulse(30, 1'b1);
    chk("R8 nothing after cancel", wr_seen - w0, 0);

    // R5 start while blank already high
    @(posedge clk); #2 hblank = 1'b1; line_visible = 1'b1;
    wr_reg(3'd4, 8'h81);
    w0 = wr_seen;
    repeat (25) @(posedge clk);
    chk("R5 level alone starts nothing", wr_seen - w0, 0);
    #2 hblank = 1'b0;
    hb_pulse(20, 1'b1);
    hb_pulse(20, 1'b1);
    chk("R5 two blocks on two rises", wr_seen - w0, 32);
    rd_chk("R7 line transfer finished", 3'd4, 8'hFF);

    done_flag = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #2000000;
    if (!done_flag) begin
      done_flag = 1;
      checks++;
      failures++;
      $display("FAIL watchdog expired actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule